// File: doc/BRIEF.md
# Event-Matched Region-of-Interest Merger

This block joins two streams of region-of-interest records that describe the same detector event. The early source is fast and delivers events in trigger order. Its records go straight into a slot buffer. A small tag table notes, for each filled slot, the event number it holds and how many records it has. The late source is slow and may present events in any order. When it has handed over all records of one event, the block looks that event number up in the tag table. It then emits one framed list that contains the stored early records followed by the late ones.

A frame opens with a header beat that carries the event number and the total record count. It closes with an end marker on the final record. The slot that was used is released once the frame has gone out. If every slot is taken when an early event begins, that event is dropped and a one-cycle overflow pulse is raised. A late event whose number is not in the table produces a frame that holds only its own records, and its header carries a miss flag.

Top module: `roi_event_merger`

## Requirements
- R1: After reset, o_valid and o_overflow are 0 and both f_ready and s_ready are 1.
- R2: f_ready stays 1 at all times, so an early-source record is accepted on every cycle in which f_valid is 1. Each early event is framed by f_last on its final record.
- R3: A merged frame is a header beat (o_hdr=1) whose o_data bits [7:0] hold the event number and bits [14:8] hold the total record count. The stored early records follow in arrival order, then the late records in arrival order. o_last is 1 only on the final beat.
- R4: Late events may arrive in any order, and each one is matched to the early records stored under its own event number.
- R5: A late event with no stored early entry yields a header whose count is the late count alone and whose o_miss is 1, followed only by the late records. o_miss is 0 on every other beat.
- R6: A slot is freed when its frame completes, so a second late event with the same number is treated as a miss.
- R7: When an early event's first record is accepted while all 16 slots are in use, o_overflow is 1 for exactly the next cycle and the event is discarded, so a later late event with that number misses. o_overflow is 0 at all other times.
- R8: While o_valid is 1 and o_ready is 0, o_valid, o_data, o_hdr and o_last hold their values.
- R9: s_ready is 0 whenever a frame is being emitted (o_valid is 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_valid | input | 1 | Early-source record valid |
| f_ready | output | 1 | Early-source ready (always 1) |
| f_evt | input | 8 | Early-source event number |
| f_rec | input | 42 | Early-source record |
| f_last | input | 1 | Final record of an early event |
| s_valid | input | 1 | Late-source record valid |
| s_ready | output | 1 | Late-source ready |
| s_evt | input | 8 | Late-source event number |
| s_rec | input | 42 | Late-source record |
| s_last | input | 1 | Final record of a late event |
| o_valid | output | 1 | Output beat valid |
| o_ready | input | 1 | Downstream ready |
| o_data | output | 42 | Header or record |
| o_hdr | output | 1 | Header beat marker (frame start) |
| o_last | output | 1 | Final beat marker (frame end) |
| o_miss | output | 1 | Header flag: no early entry was found |
| o_overflow | output | 1 | One-cycle pulse: an early event was dropped |

## Verification
The bench sends late events in an order that differs from the order in which their early events were stored. A design that kept a FIFO instead of matching by event number would therefore emit records from the wrong event. It repeats a late event number after that event has been merged, and a design that never frees slots would then re-emit stale records instead of flagging a miss. It fills all sixteen slots, pushes one more event, and checks the overflow pulse cycle by cycle. It also confirms that the dropped event later misses and that a freed slot can be reused. Downstream backpressure is applied throughout, which exposes any beat that changes or is lost while stalled.

// File: rtl/roi_merge_pkg.sv
package roi_merge_pkg;
  localparam int ROW_W = 10;
  localparam int COL_W = 8;
  localparam int SNS_W = 6;
  localparam int REC_W = 2 * ROW_W + 2 * COL_W + SNS_W;

  typedef struct packed {
    logic [ROW_W-1:0] row_first;
    logic [ROW_W-1:0] row_final;
    logic [COL_W-1:0] col_first;
    logic [COL_W-1:0] col_final;
    logic [SNS_W-1:0] sensor;
  } roi_rec_t;
endpackage

// File: rtl/roi_rec_store.sv
module roi_rec_store #(
  parameter int WORDS = 512,
  parameter int REC_W = 42
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] waddr,
  input  logic [REC_W-1:0]         wdata,
  input  logic [$clog2(WORDS)-1:0] raddr,
  output logic [REC_W-1:0]         rdata
);
  logic [REC_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/roi_slot_table.sv
module roi_slot_table #(
  parameter int SLOTS = 16,
  parameter int EVT_W = 8,
  parameter int CNT_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     set_en,
  input  logic [$clog2(SLOTS)-1:0] set_slot,
  input  logic [EVT_W-1:0]         set_evt,
  input  logic [CNT_W-1:0]         set_cnt,
  input  logic                     clr_en,
  input  logic [$clog2(SLOTS)-1:0] clr_slot,
  input  logic [EVT_W-1:0]         look_evt,
  output logic                     look_hit,
  output logic [$clog2(SLOTS)-1:0] look_slot,
  output logic [CNT_W-1:0]         look_cnt,
  output logic                     free_any,
  output logic [$clog2(SLOTS)-1:0] free_slot
);
  localparam int SLOT_W = $clog2(SLOTS);

  logic [SLOTS-1:0] used;
  logic [EVT_W-1:0] tag [SLOTS];
  logic [CNT_W-1:0] cnt [SLOTS];
  logic [SLOTS-1:0] match;

  for (genvar i = 0; i < SLOTS; i++) begin : g_match
    assign match[i] = used[i] && (tag[i] == look_evt);
  end

  // lowest index wins for both the match and the free-slot search
  always_comb begin
    look_hit  = 1'b0;
    look_slot = '0;
    look_cnt  = '0;
    free_any  = 1'b0;
    free_slot = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (match[i]) begin
        look_hit  = 1'b1;
        look_slot = SLOT_W'(i);
        look_cnt  = cnt[i];
      end
      if (!used[i]) begin
        free_any  = 1'b1;
        free_slot = SLOT_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used <= '0;
    end else begin
      if (clr_en) used[clr_slot] <= 1'b0;
      if (set_en) used[set_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) begin
      tag[set_slot] <= set_evt;
      cnt[set_slot] <= set_cnt;
    end
  end

  AST_SET_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !used[set_slot]); // R2
  AST_CLR_ONLY_USED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> used[clr_slot]); // R6
endmodule

// File: rtl/roi_event_merger.sv
module roi_event_merger #(
  parameter int EVT_W = 8,
  parameter int SLOTS = 16,
  parameter int DEPTH = 32,
  parameter int REC_W = roi_merge_pkg::REC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             f_valid,
  output logic             f_ready,
  input  logic [EVT_W-1:0] f_evt,
  input  logic [REC_W-1:0] f_rec,
  input  logic             f_last,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [EVT_W-1:0] s_evt,
  input  logic [REC_W-1:0] s_rec,
  input  logic             s_last,
  output logic             o_valid,
  input  logic             o_ready,
  output logic [REC_W-1:0] o_data,
  output logic             o_hdr,
  output logic             o_last,
  output logic             o_miss,
  output logic             o_overflow
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int TOT_W  = $clog2(2 * DEPTH + 1);
  localparam int WORDS  = SLOTS * DEPTH;
  localparam int ADDR_W = $clog2(WORDS);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  typedef enum logic [1:0] {ST_COLLECT, ST_HDR, ST_FAST, ST_SLOW} mstate_t;

  function automatic logic [ADDR_W-1:0] rec_addr(input logic [SLOT_W-1:0] slot,
                                                 input logic [IDX_W-1:0] idx);
    return ADDR_W'(slot * DEPTH + idx);
  endfunction

  function automatic logic [REC_W-1:0] make_header(input logic [EVT_W-1:0] evt,
                                                   input logic [CNT_W-1:0] n_early,
                                                   input logic [CNT_W-1:0] n_late);
    logic [TOT_W-1:0] total;
    total = TOT_W'(n_early) + TOT_W'(n_late);
    return REC_W'({total, evt});
  endfunction

  // table and store wiring
  logic              set_en, clr_en, look_hit, free_any;
  logic [SLOT_W-1:0] set_slot, clr_slot, look_slot, free_slot;
  logic [CNT_W-1:0]  set_cnt, look_cnt;
  logic              st_we;
  logic [ADDR_W-1:0] st_waddr, st_raddr;
  logic [REC_W-1:0]  st_rdata;

  // early-source write side
  logic              f_busy, f_drop, ovf_q;
  logic [SLOT_W-1:0] f_slot;
  logic [CNT_W-1:0]  f_cnt;
  logic              f_first, f_keep, f_room;
  logic [SLOT_W-1:0] f_wslot;
  logic [CNT_W-1:0]  f_idx, f_cnt_nx;

  assign f_ready  = 1'b1;
  assign f_first  = f_valid && !f_busy;
  assign f_wslot  = f_first ? free_slot : f_slot;
  assign f_keep   = f_first ? free_any : !f_drop;
  assign f_idx    = f_first ? '0 : f_cnt;
  assign f_room   = f_idx < CAP;
  assign f_cnt_nx = f_room ? f_idx + CNT_W'(1) : f_idx;
  assign st_we    = f_valid && f_keep && f_room;
  assign st_waddr = rec_addr(f_wslot, f_idx[IDX_W-1:0]);
  assign set_en   = f_valid && f_last && f_keep;
  assign set_slot = f_wslot;
  assign set_cnt  = f_cnt_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_busy <= 1'b0;
      f_drop <= 1'b0;
      f_slot <= '0;
      f_cnt  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      ovf_q <= f_first && !free_any;
      if (f_valid) begin
        f_busy <= !f_last;
        if (f_first) begin
          f_drop <= !free_any;
          f_slot <= free_slot;
        end
        if (f_keep) f_cnt <= f_cnt_nx;
      end
    end
  end
  assign o_overflow = ovf_q;

  // late-source capture and frame output
  mstate_t           state;
  logic [CNT_W-1:0]  s_cnt, o_idx, m_fcnt;
  logic [SLOT_W-1:0] m_slot;
  logic              m_hit;
  logic [EVT_W-1:0]  m_evt;
  logic [REC_W-1:0]  sbuf [DEPTH];
  logic              s_take, o_fire;

  assign s_ready  = (state == ST_COLLECT);
  assign s_take   = s_valid && s_ready;
  assign o_valid  = (state != ST_COLLECT);
  assign o_fire   = o_valid && o_ready;
  assign o_hdr    = (state == ST_HDR);
  assign o_miss   = o_hdr && !m_hit;
  assign o_last   = (state == ST_SLOW) && (o_idx == s_cnt - CNT_W'(1));
  assign st_raddr = rec_addr(m_slot, o_idx[IDX_W-1:0]);
  assign clr_en   = (state == ST_SLOW) && o_fire && o_last && m_hit;
  assign clr_slot = m_slot;

  always_comb begin
    case (state)
      ST_HDR:  o_data = make_header(m_evt, m_fcnt, s_cnt);
      ST_FAST: o_data = st_rdata;
      ST_SLOW: o_data = sbuf[o_idx[IDX_W-1:0]];
      default: o_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (s_take && s_cnt < CAP) sbuf[s_cnt[IDX_W-1:0]] <= s_rec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_COLLECT;
      s_cnt  <= '0;
      o_idx  <= '0;
      m_fcnt <= '0;
      m_slot <= '0;
      m_hit  <= 1'b0;
      m_evt  <= '0;
    end else begin
      case (state)
        ST_COLLECT: if (s_take) begin
          if (s_cnt < CAP) s_cnt <= s_cnt + CNT_W'(1);
          if (s_last) begin
            m_evt  <= s_evt;
            m_hit  <= look_hit;
            m_slot <= look_slot;
            m_fcnt <= look_hit ? look_cnt : '0;
            state  <= ST_HDR;
          end
        end
        ST_HDR: if (o_fire) begin
          o_idx <= '0;
          state <= m_hit ? ST_FAST : ST_SLOW;
        end
        ST_FAST: if (o_fire) begin
          if (o_idx == m_fcnt - CNT_W'(1)) begin
            o_idx <= '0;
            state <= ST_SLOW;
          end else begin
            o_idx <= o_idx + CNT_W'(1);
          end
        end
        default: if (o_fire) begin
          if (o_last) begin
            s_cnt <= '0;
            o_idx <= '0;
            state <= ST_COLLECT;
          end else begin
            o_idx <= o_idx + CNT_W'(1);
          end
        end
      endcase
    end
  end

  roi_slot_table #(.SLOTS(SLOTS), .EVT_W(EVT_W), .CNT_W(CNT_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .set_en(set_en), .set_slot(set_slot), .set_evt(f_evt), .set_cnt(set_cnt),
    .clr_en(clr_en), .clr_slot(clr_slot),
    .look_evt(s_evt), .look_hit(look_hit), .look_slot(look_slot), .look_cnt(look_cnt),
    .free_any(free_any), .free_slot(free_slot)
  );

  roi_rec_store #(.WORDS(WORDS), .REC_W(REC_W)) u_store (
    .clk(clk), .we(st_we), .waddr(st_waddr), .wdata(f_rec),
    .raddr(st_raddr), .rdata(st_rdata)
  );

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && !o_ready |=> o_valid && $stable(o_data) && $stable(o_hdr) && $stable(o_last)); // R8
  AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    o_overflow |-> $past(!free_any)); // R7
  AST_FAST_HAS_RECS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAST) |-> (m_fcnt != '0)); // R3
  AST_FRAME_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(o_valid) |-> o_hdr); // R3
  AST_MISS_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    o_miss |-> (m_fcnt == '0)); // R5
endmodule

// File: tb/roi_event_merger_tb.sv
module roi_event_merger_tb;
  localparam int RW = 42;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic f_valid = 1'b0, f_last = 1'b0, s_valid = 1'b0, s_last = 1'b0, o_ready = 1'b0;
  logic [7:0] f_evt = '0, s_evt = '0;
  logic [RW-1:0] f_rec = '0, s_rec = '0;
  logic f_ready, s_ready, o_valid, o_hdr, o_last, o_miss, o_overflow;
  logic [RW-1:0] o_data;

  always #10 clk = ~clk;

  roi_event_merger u_dut (
    .clk(clk), .rst_n(rst_n),
    .f_valid(f_valid), .f_ready(f_ready), .f_evt(f_evt), .f_rec(f_rec), .f_last(f_last),
    .s_valid(s_valid), .s_ready(s_ready), .s_evt(s_evt), .s_rec(s_rec), .s_last(s_last),
    .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data), .o_hdr(o_hdr),
    .o_last(o_last), .o_miss(o_miss), .o_overflow(o_overflow)
  );

  int checks = 0, errors = 0, cyc = 0, bp_cnt = 0;
  bit exp_ovf = 0, done = 0;

  // reference model: per event number, held early records
  bit            m_valid [256];
  int            m_cnt   [256];
  logic [RW-1:0] m_rec   [256][32];
  int            n_held = 0;
  logic [RW-1:0] exp_data [$];
  logic [2:0]    exp_flag [$];   // {hdr, last, miss}

  logic [RW-1:0] prev_data;
  logic [2:0]    prev_flag;
  bit            prev_stall = 0;

  function automatic logic [RW-1:0] mkrec(int e, int i, int src);
    return RW'((src << 20) | (e << 8) | i) ^ RW'(64'h2A5 << 24);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // downstream backpressure pattern
  always @(posedge clk) begin
    #1;
    bp_cnt++;
    o_ready = ((bp_cnt % 5) != 3) && ((bp_cnt % 7) != 0);
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      if (cyc > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        finish_run();
      end
      chk(f_ready == 1'b1, "R2 f_ready", 64'(f_ready), 64'(1));
      chk(o_overflow == exp_ovf, "R7 overflow pulse", 64'(o_overflow), 64'(exp_ovf));
      if (o_valid) chk(s_ready == 1'b0, "R9 s_ready during frame", 64'(s_ready), 64'(0));
      if (prev_stall)
        chk(o_valid && o_data == prev_data && {o_hdr, o_last, o_miss} == prev_flag,
            "R8 hold under stall", 64'({o_valid, o_hdr, o_last, o_miss, o_data}),
            64'({1'b1, prev_flag, prev_data}));
      if (o_valid && !o_hdr) chk(o_miss == 1'b0, "R5 miss only on header", 64'(o_miss), 64'(0));
      if (o_valid && o_ready) begin
        if (exp_data.size() == 0) begin
          chk(1'b0, "R3 unexpected beat", 64'(o_data), 64'(0));
        end else begin
          logic [RW-1:0] ed;
          logic [2:0]    ef;
          ed = exp_data.pop_front();
          ef = exp_flag.pop_front();
          chk(o_data == ed && {o_hdr, o_last, o_miss} == ef, "R3 R4 R5 frame beat",
              64'({o_hdr, o_last, o_miss, o_data}), 64'({ef, ed}));
        end
      end
      prev_stall = o_valid && !o_ready;
      prev_data  = o_data;
      prev_flag  = {o_hdr, o_last, o_miss};
    end
  end

  task automatic send_fast(int e, int n);
    bit drop;
    drop = (n_held >= 16);
    if (!drop) begin
      m_valid[e] = 1;
      m_cnt[e]   = n;
      for (int i = 0; i < n; i++) m_rec[e][i] = mkrec(e, i, 0);
      n_held++;
    end
    for (int i = 0; i < n; i++) begin
      f_valid = 1'b1;
      f_evt   = 8'(e);
      f_rec   = mkrec(e, i, 0);
      f_last  = (i == n - 1);
      @(posedge clk);
      exp_ovf = (i == 0) && drop;
      #1;
    end
    f_valid = 1'b0;
    f_last  = 1'b0;
    @(posedge clk);
    exp_ovf = 0;
    #1;
  endtask

  task automatic send_slow(int e, int n);
    int fc;
    bit hit;
    hit = m_valid[e];
    fc  = hit ? m_cnt[e] : 0;
    exp_data.push_back(RW'(e) | (RW'(fc + n) << 8));
    exp_flag.push_back({1'b1, 1'b0, !hit});
    for (int i = 0; i < fc; i++) begin
      exp_data.push_back(m_rec[e][i]);
      exp_flag.push_back(3'b000);
    end
    for (int i = 0; i < n; i++) begin
      exp_data.push_back(mkrec(e, i, 1));
      exp_flag.push_back({1'b0, (i == n - 1), 1'b0});
    end
    if (hit) begin
      m_valid[e] = 0;
      n_held--;
    end
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b1;
      s_evt   = 8'(e);
      s_rec   = mkrec(e, i, 1);
      s_last  = (i == n - 1);
      while (!s_ready) begin
        @(posedge clk);
        #1;
      end
      @(posedge clk);
      #1;
    end
    s_valid = 1'b0;
    s_last  = 1'b0;
    while (exp_data.size() != 0) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) m_valid[i] = 0;
    repeat (4) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(o_valid == 1'b0, "R1 o_valid", 64'(o_valid), 64'(0));
    chk(o_overflow == 1'b0, "R1 o_overflow", 64'(o_overflow), 64'(0));
    chk(f_ready && s_ready, "R1 ready", 64'({f_ready, s_ready}), 64'(3));
    @(posedge clk);
    #1;

    // R3 R4: stored in order, merged out of order
    send_fast(10, 3);
    send_fast(11, 1);
    send_fast(12, 5);
    send_slow(12, 2);
    send_slow(10, 1);
    send_slow(11, 3);
    // R5: nothing stored for this event
    send_slow(50, 2);
    // R6: event 10 already merged, slot freed
    send_slow(10, 1);

    // R7: fill all slots, then one more event is dropped
    for (int e = 20; e < 36; e++) send_fast(e, 2);
    send_fast(40, 3);
    send_slow(40, 1);
    send_slow(27, 2);
    send_fast(41, 4);
    send_slow(41, 1);
    send_slow(35, 3);
    send_slow(20, 1);

    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(exp_data.size() == 0, "R3 all frames emitted", 64'(exp_data.size()), 64'(0));
    chk(o_valid == 1'b0, "R3 idle after frames", 64'(o_valid), 64'(0));
    done = 1;
    finish_run();
  end
endmodule